// File: doc/BRIEF.md
# Locked Bus Arbitration Controller

This block decides which of two masters drives a shared address and data bus: a processor integer unit, which owns the bus by default, or a single DMA master. The processor drives its bus-lock, atomic load-store, read and active-low write strobes unregistered. The block registers them on the clock, and every arbitration decision is made from those registered copies. A bus lock, or any cycle of an atomic load-store, counts as a busy bus. An atomic load-store keeps its flag up through its load cycle and both of its store cycles. While the bus is busy, no hold request goes to the processor and no grant goes to the DMA master. After the bus stops being busy, a guard period of `GUARD_CYCLES` cycles must pass before a hold request may be raised.

The controller is a five-state machine. ST_FREE: the processor owns the bus and nothing is pending. ST_LOCKED: the registered lock or atomic flag is high. ST_GUARD: the post-lock guard period is running. ST_HANDOFF: the hold request is raised and the grant is not yet given. ST_DMA: both hold and grant are high. The transitions are named as follows. FREE-to-LOCKED and GUARD-to-LOCKED are taken when the bus becomes busy. LOCKED-to-GUARD is taken when the busy condition clears. GUARD-to-HANDOFF is taken when the guard has expired and a request is waiting. GUARD-to-FREE is taken when the guard has expired and no request is waiting. FREE-to-HANDOFF is taken on a request while the bus is idle. HANDOFF-to-DMA is the grant. HANDOFF-to-LOCKED is a retraction: the processor locked the bus in the same cycle that hold went up. HANDOFF-to-FREE and DMA-to-FREE are taken when the request is withdrawn.

While the DMA master holds the grant, the registered bus-control outputs carry the DMA master's strobes and ignore the processor's. The memory write enable leaving the block is the registered write strobe, forced inactive whenever the memory-hold input or the memory-exception input (both active low) is asserted.

Top module: `bus_lock_arbiter`

## Requirements
- R1: `bus_lock_o`, `bus_atomic_o`, `bus_rd_o` and the write strobe behind `mem_we_n_o` show the owning master's inputs as sampled at the previous rising clock edge. A change at an input is not visible in the same cycle.
- R2: `dma_grant_o` rises only in the cycle after one in which `cpu_hold_o` was high and the registered bus was not busy. If the registered bus becomes busy while hold is up and grant is not, hold drops on the next cycle and no grant is given.
- R3: `cpu_hold_o` rises only when the registered bus was not busy in each of the two preceding cycles. With `GUARD_CYCLES` = 1 and a request already waiting, hold first rises three cycles after the last busy cycle.
- R4: A high registered atomic load-store flag blocks hold and grant exactly as a high registered lock does, with the lock input low.
- R5: While `dma_grant_o` is high and `dma_req_i` stays high, the grant stays high. One cycle after `dma_req_i` drops, both `dma_grant_o` and `cpu_hold_o` are low.
- R6: While `dma_grant_o` is high, the registered bus-control outputs carry the DMA master's inputs from the previous edge, and changes on the processor's inputs have no effect on them.
- R7: `mem_we_n_o` is 1 whenever `mem_hold_n_i` or `mem_exc_n_i` is 0. Otherwise it equals the registered write strobe, where 0 means write and 1 means read.
- R8: While `rst_n` is low, `cpu_hold_o` and `dma_grant_o` are 0, `bus_lock_o` and `bus_atomic_o` are 0, and `bus_rd_o` and `mem_we_n_o` are 1. The processor owns the bus in ST_FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_lock_i | input | 1 | Processor bus lock, unregistered |
| cpu_atomic_i | input | 1 | Processor atomic load-store flag, unregistered |
| cpu_rd_i | input | 1 | Processor read flag: 1 read, 0 write |
| cpu_wr_n_i | input | 1 | Processor write strobe, active low |
| dma_req_i | input | 1 | DMA master bus request |
| dma_lock_i | input | 1 | DMA bus lock |
| dma_atomic_i | input | 1 | DMA atomic load-store flag |
| dma_rd_i | input | 1 | DMA read flag: 1 read, 0 write |
| dma_wr_n_i | input | 1 | DMA write strobe, active low |
| mem_hold_n_i | input | 1 | Memory hold, active low |
| mem_exc_n_i | input | 1 | Memory exception, active low |
| cpu_hold_o | output | 1 | Hold request to the processor |
| dma_grant_o | output | 1 | Bus grant to the DMA master |
| bus_lock_o | output | 1 | Registered lock of the owning master |
| bus_atomic_o | output | 1 | Registered atomic flag of the owning master |
| bus_rd_o | output | 1 | Registered read flag of the owning master |
| mem_we_n_o | output | 1 | Qualified memory write enable, active low |

## Verification
The bench places a DMA request in the middle of a locked store-double and expects no hold until the guard has run out. A design that used the lock without registering it, or that dropped the guard, would raise hold one or two cycles early. In another case the processor locks in the same cycle that hold rises. A design without the HANDOFF retraction would grant the DMA master a locked bus. The bench also runs an atomic sequence with the lock input low, which catches a design that blocks only on lock. Separate cases raise memory hold and memory exception during a write, which catches a write enable that is not gated. The bench further toggles processor strobes during a grant, applies a reset mid-grant, and checks the one-cycle latency of the registered strobes.

// File: rtl/bla_pkg.sv
package bla_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_LOCKED,
        ST_GUARD,
        ST_HANDOFF,
        ST_DMA
    } arb_state_e;

    typedef struct packed {
        logic lock;
        logic atomic;
        logic rd;
        logic wr_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{lock: 1'b0, atomic: 1'b0, rd: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/bla_ctl_latch.sv
module bla_ctl_latch
    import bla_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel_dma,
    input  bus_ctl_t cpu_ctl,
    input  bus_ctl_t dma_ctl,
    output bus_ctl_t ctl_q
);

    bus_ctl_t ctl_d;

    // Source chosen by the owner of the coming cycle.
    assign ctl_d = sel_dma ? dma_ctl : cpu_ctl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/bla_arb_fsm.sv
module bla_arb_fsm
    import bla_pkg::*;
#(
    parameter int GUARD_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_q,
    input  logic dma_req,
    output logic hold,
    output logic grant,
    output logic dma_next
);

    localparam int CNT_W = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES + 1) : 1;
    localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYCLES - 1);

    arb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FREE: begin
                if (busy_q) begin
                    state_d = ST_LOCKED;
                end else if (dma_req) begin
                    state_d = ST_HANDOFF;
                end
            end
            ST_LOCKED: begin
                if (!busy_q) begin
                    state_d = ST_GUARD;
                    cnt_d   = GUARD_LOAD;
                end
            end
            ST_GUARD: begin
                if (busy_q) begin
                    state_d = ST_LOCKED;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (dma_req) begin
                    state_d = ST_HANDOFF;
                end else begin
                    state_d = ST_FREE;
                end
            end
            ST_HANDOFF: begin
                if (!dma_req) begin
                    state_d = ST_FREE;
                end else if (busy_q) begin
                    state_d = ST_LOCKED;
                end else begin
                    state_d = ST_DMA;
                end
            end
            ST_DMA: begin
                if (!dma_req) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_comb begin
        hold  = 1'b0;
        grant = 1'b0;
        unique case (state_q)
            ST_HANDOFF: hold = 1'b1;
            ST_DMA: begin
                hold  = 1'b1;
                grant = 1'b1;
            end
            default: begin
                hold  = 1'b0;
                grant = 1'b0;
            end
        endcase
    end

    assign dma_next = (state_d == ST_DMA);

endmodule

// File: rtl/bla_we_gate.sv
module bla_we_gate #(
    parameter int NUM_BLOCK = 2
) (
    input  logic                 wr_n_q,
    input  logic [NUM_BLOCK-1:0] block_n,
    output logic                 we_n
);

    logic [NUM_BLOCK-1:0] blocked;

    for (genvar g = 0; g < NUM_BLOCK; g++) begin : g_block
        assign blocked[g] = ~block_n[g];
    end

    assign we_n = wr_n_q | (|blocked);

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
    import bla_pkg::*;
#(
    parameter int GUARD_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_lock_i,
    input  logic cpu_atomic_i,
    input  logic cpu_rd_i,
    input  logic cpu_wr_n_i,
    input  logic dma_req_i,
    input  logic dma_lock_i,
    input  logic dma_atomic_i,
    input  logic dma_rd_i,
    input  logic dma_wr_n_i,
    input  logic mem_hold_n_i,
    input  logic mem_exc_n_i,
    output logic cpu_hold_o,
    output logic dma_grant_o,
    output logic bus_lock_o,
    output logic bus_atomic_o,
    output logic bus_rd_o,
    output logic mem_we_n_o
);

    bus_ctl_t cpu_ctl, dma_ctl, ctl_q;
    logic     dma_next;
    logic     busy_q;

    assign cpu_ctl = '{lock: cpu_lock_i, atomic: cpu_atomic_i, rd: cpu_rd_i, wr_n: cpu_wr_n_i};
    assign dma_ctl = '{lock: dma_lock_i, atomic: dma_atomic_i, rd: dma_rd_i, wr_n: dma_wr_n_i};

    bla_ctl_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_dma (dma_next),
        .cpu_ctl (cpu_ctl),
        .dma_ctl (dma_ctl),
        .ctl_q   (ctl_q)
    );

    assign busy_q = ctl_q.lock | ctl_q.atomic;

    bla_arb_fsm #(
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_q   (busy_q),
        .dma_req  (dma_req_i),
        .hold     (cpu_hold_o),
        .grant    (dma_grant_o),
        .dma_next (dma_next)
    );

    bla_we_gate #(
        .NUM_BLOCK (2)
    ) u_we (
        .wr_n_q  (ctl_q.wr_n),
        .block_n ({mem_hold_n_i, mem_exc_n_i}),
        .we_n    (mem_we_n_o)
    );

    assign bus_lock_o   = ctl_q.lock;
    assign bus_atomic_o = ctl_q.atomic;
    assign bus_rd_o     = ctl_q.rd;

endmodule

// File: rtl/bus_lock_arbiter_chk.sv
module bus_lock_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_rd_i,
    input logic dma_rd_i,
    input logic dma_req_i,
    input logic mem_hold_n_i,
    input logic mem_exc_n_i,
    input logic cpu_hold_o,
    input logic dma_grant_o,
    input logic bus_lock_o,
    input logic bus_atomic_o,
    input logic bus_rd_o,
    input logic mem_we_n_o
);

    logic cpu_busy;
    logic busy_d1, busy_d2, past_ok;

    assign cpu_busy = (bus_lock_o | bus_atomic_o) & ~dma_grant_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_d1 <= 1'b0;
            busy_d2 <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            busy_d1 <= cpu_busy;
            busy_d2 <= busy_d1;
            past_ok <= 1'b1;
        end
    end

    assert_cpu_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !dma_grant_o) |-> (bus_rd_o == $past(cpu_rd_i)));

    assert_grant_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_grant_o) |-> ($past(cpu_hold_o) && !$past(cpu_busy)));

    assert_hold_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold_o) |-> (!busy_d1 && !busy_d2));

    assert_grant_persist_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_grant_o && dma_req_i) |=> dma_grant_o);

    assert_grant_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_grant_o && !dma_req_i) |=> (!dma_grant_o && !cpu_hold_o));

    assert_dma_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dma_grant_o) |-> (bus_rd_o == $past(dma_rd_i)));

    assert_we_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_hold_n_i || !mem_exc_n_i) |-> mem_we_n_o);

    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |-> (!cpu_hold_o && !dma_grant_o && !bus_lock_o && mem_we_n_o));

endmodule

bind bus_lock_arbiter bus_lock_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_rd_i     (cpu_rd_i),
    .dma_rd_i     (dma_rd_i),
    .dma_req_i    (dma_req_i),
    .mem_hold_n_i (mem_hold_n_i),
    .mem_exc_n_i  (mem_exc_n_i),
    .cpu_hold_o   (cpu_hold_o),
    .dma_grant_o  (dma_grant_o),
    .bus_lock_o   (bus_lock_o),
    .bus_atomic_o (bus_atomic_o),
    .bus_rd_o     (bus_rd_o),
    .mem_we_n_o   (mem_we_n_o)
);

// File: tb/sim_bus_lock_arbiter.sv
module sim_bus_lock_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic cpu_lock_i = 1'b0, cpu_atomic_i = 1'b0, cpu_rd_i = 1'b1, cpu_wr_n_i = 1'b1;
    logic dma_req_i = 1'b0, dma_lock_i = 1'b0, dma_atomic_i = 1'b0;
    logic dma_rd_i = 1'b0, dma_wr_n_i = 1'b0;
    logic mem_hold_n_i = 1'b1, mem_exc_n_i = 1'b1;
    logic cpu_hold_o, dma_grant_o, bus_lock_o, bus_atomic_o, bus_rd_o, mem_we_n_o;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_lock_arbiter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_lock_i   (cpu_lock_i),
        .cpu_atomic_i (cpu_atomic_i),
        .cpu_rd_i     (cpu_rd_i),
        .cpu_wr_n_i   (cpu_wr_n_i),
        .dma_req_i    (dma_req_i),
        .dma_lock_i   (dma_lock_i),
        .dma_atomic_i (dma_atomic_i),
        .dma_rd_i     (dma_rd_i),
        .dma_wr_n_i   (dma_wr_n_i),
        .mem_hold_n_i (mem_hold_n_i),
        .mem_exc_n_i  (mem_exc_n_i),
        .cpu_hold_o   (cpu_hold_o),
        .dma_grant_o  (dma_grant_o),
        .bus_lock_o   (bus_lock_o),
        .bus_atomic_o (bus_atomic_o),
        .bus_rd_o     (bus_rd_o),
        .mem_we_n_o   (mem_we_n_o)
    );

    // {tag, {cpu_lock, cpu_atomic, cpu_wr_n(=cpu_rd), dma_req, mem_hold_n, mem_exc_n},
    //  {hold, grant, bus_lock, mem_we_n}} ; expectation is one clock after applying.
    localparam int NV = 26;
    localparam logic [13:0] VEC [NV] = '{
        {4'd1, 6'b001011, 4'b0001},
        {4'd7, 6'b000011, 4'b0000},
        {4'd7, 6'b000001, 4'b0001},
        {4'd7, 6'b000010, 4'b0001},
        {4'd1, 6'b101011, 4'b0011},
        {4'd2, 6'b100111, 4'b0010},
        {4'd2, 6'b100111, 4'b0010},
        {4'd1, 6'b001111, 4'b0001},
        {4'd3, 6'b001111, 4'b0001},
        {4'd3, 6'b001111, 4'b1001},
        {4'd6, 6'b001111, 4'b1100},
        {4'd6, 6'b101111, 4'b1100},
        {4'd5, 6'b001011, 4'b0001},
        {4'd4, 6'b011111, 4'b1001},
        {4'd2, 6'b011111, 4'b0001},
        {4'd4, 6'b010111, 4'b0000},
        {4'd7, 6'b010110, 4'b0001},
        {4'd4, 6'b001111, 4'b0001},
        {4'd3, 6'b001111, 4'b0001},
        {4'd3, 6'b101111, 4'b1011},
        {4'd2, 6'b101111, 4'b0011},
        {4'd2, 6'b001011, 4'b0001},
        {4'd3, 6'b001011, 4'b0001},
        {4'd3, 6'b001011, 4'b0001},
        {4'd5, 6'b001111, 4'b1001},
        {4'd5, 6'b001011, 4'b0001}
    };

    function automatic string req_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [5:0] v);
        cpu_lock_i   = v[5];
        cpu_atomic_i = v[4];
        cpu_wr_n_i   = v[3];
        cpu_rd_i     = v[3];
        dma_req_i    = v[2];
        mem_hold_n_i = v[1];
        mem_exc_n_i  = v[0];
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("[TB] FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        // R8: idle outputs during reset
        check("R8", "reset hold/grant/lock/atomic/rd/we_n",
              {2'b0, cpu_hold_o, dma_grant_o, bus_lock_o, bus_atomic_o, bus_rd_o, mem_we_n_o},
              8'b00000011);
        @(negedge clk);
        rst_n = 1'b1;

        apply(VEC[0][9:4]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(req_name(VEC[i][13:10]), $sformatf("vector %0d hold/grant/lock/we_n", i),
                  {4'b0, cpu_hold_o, dma_grant_o, bus_lock_o, mem_we_n_o},
                  {4'b0, VEC[i][3:0]});
            if (i < NV - 1) apply(VEC[i+1][9:4]);
        end

        // R1: read flag change is seen one clock later, not at once
        cpu_rd_i   = 1'b0;
        cpu_wr_n_i = 1'b0;
        dma_req_i  = 1'b0;
        #1 check("R1", "rd same cycle", {7'b0, bus_rd_o}, 8'd1);
        @(negedge clk);
        check("R1", "rd/we_n next cycle", {6'b0, bus_rd_o, mem_we_n_o}, 8'b00);

        // R6: processor strobes ignored while DMA holds the bus
        cpu_rd_i     = 1'b1;
        cpu_wr_n_i   = 1'b1;
        dma_req_i    = 1'b1;
        dma_rd_i     = 1'b1;
        dma_wr_n_i   = 1'b1;
        dma_atomic_i = 1'b1;
        @(negedge clk);
        check("R2", "handoff hold/grant", {6'b0, cpu_hold_o, dma_grant_o}, 8'b10);
        cpu_rd_i     = 1'b0;
        cpu_atomic_i = 1'b1;
        @(negedge clk);
        check("R6", "granted rd/atomic from DMA", {5'b0, dma_grant_o, bus_rd_o, bus_atomic_o}, 8'b111);
        cpu_lock_i = 1'b1;
        @(negedge clk);
        check("R6", "granted, processor lock ignored", {5'b0, dma_grant_o, bus_lock_o, bus_rd_o}, 8'b101);

        // R8: reset in the middle of a grant
        rst_n = 1'b0;
        #1 check("R8", "mid-grant reset hold/grant/atomic/rd/we_n",
                 {3'b0, cpu_hold_o, dma_grant_o, bus_atomic_o, bus_rd_o, mem_we_n_o}, 8'b00011);
        cpu_lock_i   = 1'b0;
        cpu_atomic_i = 1'b0;
        cpu_rd_i     = 1'b1;
        dma_req_i    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "after reset idle", {6'b0, cpu_hold_o, dma_grant_o}, 8'b00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule